// File: doc/BRIEF.md
# Phase-Editable Clock Halver

This block divides its input clock down to a square wave whose phase a control loop can move, one input-clock step at a time. In a digital phase-locked loop it sits after the up/down counter that detects phase error. That counter emits "advance" (carry) and "retard" (borrow) requests. Each advance request makes one half-period of the output one input clock shorter. Each retard request makes one half-period one input clock longer. The average output frequency therefore moves in proportion to the net request rate, and the loop can pull the output into phase with a reference.

The nominal half-period is `HALF_CYC` input clocks, with a default of 2 and a minimum of 2. This keeps the output a registered, glitch-free signal even when a half-period is shortened. Requests arrive as toggle-coded lines, so they may come from another clock domain. Each line passes through a small synchroniser. Edits that cannot be applied yet wait in a small saturating queue, and at most one edit is applied per output half-period.

Top module: `pulse_edit_div`

## Requirements
- R1: While `rstN` is low, `divClk` is low. After release, `divClk` first goes high on the `HALF_CYC`-th rising clock edge.
- R2: With no pending requests, every high phase and every low phase of `divClk` lasts exactly `HALF_CYC` clock cycles.
- R3: Each advance request makes exactly one half-period of `divClk` last `HALF_CYC-1` cycles.
- R4: Each retard request makes exactly one half-period of `divClk` last `HALF_CYC+1` cycles.
- R5: If an advance and a retard are both pending at a half-period boundary, both are consumed and the next half-period has the nominal length.
- R6: At most one edit is consumed per half-period boundary. Several queued requests are applied on successive half-periods and are never merged into one.
- R7: Each queue holds at most `2**CNT_W-1` requests. Requests beyond that are dropped and the count never wraps to a lower value.
- R8: Every level change of `carryTgl` or `borrowTgl`, in either direction, counts as exactly one request. It takes effect after `SYNC_STAGES` synchroniser flops plus one edge-detect flop.
- R9: `divClk` comes straight from a flop, and no run of `divClk` is shorter than `HALF_CYC-1` cycles or longer than `HALF_CYC+1` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that is divided |
| rstN | input | 1 | Asynchronous active-low reset |
| carryTgl | input | 1 | Advance request line; each level change is one request |
| borrowTgl | input | 1 | Retard request line; each level change is one request |
| divClk | output | 1 | Edited divided clock |

## Verification
The half-period lengths are measured at the output and sorted into nominal, shortened, lengthened and illegal runs. The bench tries several patterns: no requests, which shows the plain divide ratio; single and repeated advances or retards spaced apart, which separate the two directions and show one edit per request; and simultaneous advance-plus-retard pairs, which must leave the output untouched. Two back-to-back bursts test the queue. A burst of advances, drained as fast as it arrives, must yield one short run per request. A longer burst of retards, which drains more slowly, must lose some requests to saturation but still leave a full queue.

// File: rtl/ped_pkg.sv
`timescale 1ns/1ps
package ped_pkg;
  // Edit command from control to datapath for the half-period being loaded
  typedef struct packed {
    logic shorten;
    logic lengthen;
  } editCmdT;
endpackage

// File: rtl/ped_sync.sv
`timescale 1ns/1ps
module ped_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tglIn,
  output logic reqPulse
);
  // chain[0..SYNC_STAGES-1] synchronise, chain[SYNC_STAGES] holds last seen level
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[SYNC_STAGES-1:0], tglIn};
  end

  assign reqPulse = chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];
endmodule

// File: rtl/ped_ctrl.sv
`timescale 1ns/1ps
module ped_ctrl
  import ped_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       reqPulse,   // [0] advance, [1] retard
  input  logic             atBoundary,
  output editCmdT          editCmd,
  output logic [CNT_W-1:0] carryPend,
  output logic [CNT_W-1:0] borrowPend
);
  localparam logic [CNT_W-1:0] PEND_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] pend [2];
  logic [1:0]       havePend;
  logic [1:0]       consume;

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_queue
      assign havePend[gi] = (pend[gi] != '0);
      assign consume[gi]  = atBoundary & havePend[gi];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pend[gi] <= '0;
        end else if (reqPulse[gi] && !consume[gi] && pend[gi] != PEND_MAX) begin
          pend[gi] <= pend[gi] + 1'b1;
        end else if (consume[gi] && !reqPulse[gi]) begin
          pend[gi] <= pend[gi] - 1'b1;
        end
      end
    end
  endgenerate

  // opposite edits pending together cancel each other
  assign editCmd.shorten  = havePend[0] & ~havePend[1];
  assign editCmd.lengthen = havePend[1] & ~havePend[0];

  assign carryPend  = pend[0];
  assign borrowPend = pend[1];
endmodule

// File: rtl/ped_datapath.sv
`timescale 1ns/1ps
module ped_datapath
  import ped_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  editCmdT editCmd,
  output logic    atBoundary,
  output logic    divClk
);
  localparam int LEN_W = $clog2(HALF_CYC + 2);
  localparam logic [LEN_W-1:0] LOAD_NORM  = LEN_W'(HALF_CYC - 1);
  localparam logic [LEN_W-1:0] LOAD_SHORT = LEN_W'(HALF_CYC - 2);
  localparam logic [LEN_W-1:0] LOAD_LONG  = LEN_W'(HALF_CYC);

  logic [LEN_W-1:0] halfCnt;
  logic [LEN_W-1:0] nextLoad;

  assign atBoundary = (halfCnt == '0);

  always_comb begin
    if (editCmd.shorten)       nextLoad = LOAD_SHORT;
    else if (editCmd.lengthen) nextLoad = LOAD_LONG;
    else                       nextLoad = LOAD_NORM;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divClk  <= 1'b0;
      halfCnt <= LOAD_NORM;
    end else if (atBoundary) begin
      divClk  <= ~divClk;
      halfCnt <= nextLoad;
    end else begin
      halfCnt <= halfCnt - 1'b1;
    end
  end
endmodule

// File: rtl/pulse_edit_div.sv
`timescale 1ns/1ps
module pulse_edit_div
  import ped_pkg::*;
#(
  parameter int HALF_CYC    = 2,
  parameter int CNT_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic carryTgl,
  input  logic borrowTgl,
  output logic divClk
);
  logic [1:0]       tglVec;
  logic [1:0]       reqPulse;
  logic             atBoundary;
  editCmdT          editCmd;
  logic [CNT_W-1:0] carryPend;
  logic [CNT_W-1:0] borrowPend;

  assign tglVec = {borrowTgl, carryTgl};

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_sync
      ped_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rstN(rstN), .tglIn(tglVec[gi]), .reqPulse(reqPulse[gi])
      );
    end
  endgenerate

  ped_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqPulse(reqPulse), .atBoundary(atBoundary),
    .editCmd(editCmd), .carryPend(carryPend), .borrowPend(borrowPend)
  );

  ped_datapath #(.HALF_CYC(HALF_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .editCmd(editCmd),
    .atBoundary(atBoundary), .divClk(divClk)
  );
endmodule

// File: rtl/ped_checker.sv
`timescale 1ns/1ps
module ped_checker #(
  parameter int HALF_CYC = 2,
  parameter int CNT_W    = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             divClk,
  input logic [CNT_W-1:0] carryPend,
  input logic [CNT_W-1:0] borrowPend
);
  localparam logic [7:0] RUN_MIN = 8'(HALF_CYC - 1);
  localparam logic [7:0] RUN_MAX = 8'(HALF_CYC + 1);
  localparam logic [CNT_W-1:0] PEND_MAX = {CNT_W{1'b1}};

  logic       prevOut;
  logic       seenEdge;
  logic [7:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOut  <= 1'b0;
      seenEdge <= 1'b0;
      runLen   <= 8'd0;
    end else begin
      prevOut <= divClk;
      if (divClk != prevOut) begin
        runLen   <= 8'd1;
        seenEdge <= 1'b1;
      end else if (runLen != 8'hFF) begin
        runLen <= runLen + 8'd1;
      end
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk) !rstN |-> !divClk);

  assert_run_bounds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && divClk != prevOut) |-> (runLen >= RUN_MIN && runLen <= RUN_MAX));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (borrowPend == PEND_MAX) |=> (borrowPend >= PEND_MAX - 1'b1));

  assert_one_edit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (borrowPend < $past(borrowPend) || carryPend < $past(carryPend)) |-> (divClk != $past(divClk)));
endmodule

bind pulse_edit_div ped_checker #(.HALF_CYC(HALF_CYC), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .divClk(divClk),
  .carryPend(carryPend), .borrowPend(borrowPend)
);

// File: tb/sim_pulse_edit_div.sv
`timescale 1ns/1ps
module sim_pulse_edit_div;
  localparam int HALF_CYC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic carryTgl = 1'b0;
  logic borrowTgl = 1'b0;
  logic divClk;

  int checks = 0;
  int errors = 0;
  int nShort = 0, nLong = 0, nOdd = 0;
  int runLen = 0;
  logic lastOut = 1'b0;
  bit skipFirst = 1'b1;

  always #4 clk = ~clk;

  pulse_edit_div u0 (
    .clk(clk), .rstN(rstN), .carryTgl(carryTgl),
    .borrowTgl(borrowTgl), .divClk(divClk)
  );

  // run-length monitor: sorts each completed half-period of divClk
  always @(negedge clk) begin
    if (!rstN) begin
      runLen = 0; lastOut = 1'b0; skipFirst = 1'b1;
    end else begin
      if (divClk !== lastOut) begin
        if (skipFirst) skipFirst = 1'b0;
        else if (runLen == HALF_CYC - 1) nShort++;
        else if (runLen == HALF_CYC + 1) nLong++;
        else if (runLen != HALF_CYC) nOdd++;
        runLen = 1;
      end else begin
        runLen++;
      end
      lastOut = divClk;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode: 0 none, 1 advance, 2 retard, 3 both together
  task automatic sendReq(input int mode);
    @(negedge clk);
    if (mode == 1 || mode == 3) carryTgl = ~carryTgl;
    if (mode == 2 || mode == 3) borrowTgl = ~borrowTgl;
    repeat (10) @(negedge clk);
  endtask

  task automatic clearTally();
    @(negedge clk);
    nShort = 0; nLong = 0; nOdd = 0;
  endtask

  // {mode[13:12], count[11:8], expShort[7:4], expLong[3:0]}
  localparam int NVEC = 6;
  localparam logic [13:0] VEC [NVEC] = '{
    {2'd0, 4'd3, 4'd0, 4'd0},   // R2 idle
    {2'd1, 4'd1, 4'd1, 4'd0},   // R3 single advance
    {2'd2, 4'd1, 4'd0, 4'd1},   // R4 single retard
    {2'd1, 4'd3, 4'd3, 4'd0},   // R3 R8 three advances
    {2'd2, 4'd3, 4'd0, 4'd3},   // R4 R8 three retards
    {2'd3, 4'd2, 4'd0, 4'd0}    // R5 cancelling pairs
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..R9 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(divClk === 1'b0, "R1 low in reset", int'(divClk), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(divClk === 1'b0, "R1 low after first edge", int'(divClk), 0);
    @(negedge clk);
    check(divClk === 1'b1, "R1 rises on edge HALF_CYC", int'(divClk), 1);
    repeat (6) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      int mode, cnt, expS, expL;
      mode = int'(VEC[v][13:12]);
      cnt  = int'(VEC[v][11:8]);
      expS = int'(VEC[v][7:4]);
      expL = int'(VEC[v][3:0]);
      clearTally();
      for (int k = 0; k < cnt; k++) sendReq(mode);
      repeat (30) @(negedge clk);
      check(nShort == expS, $sformatf("R3 R5 vec%0d short runs", v), nShort, expS);
      check(nLong  == expL, $sformatf("R4 R5 vec%0d long runs", v), nLong, expL);
      check(nOdd == 0, $sformatf("R2 R9 vec%0d illegal runs", v), nOdd, 0);
    end

    // R6: back-to-back advances are applied one per half-period, none merged
    clearTally();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      carryTgl = ~carryTgl;
    end
    repeat (40) @(negedge clk);
    check(nShort == 3, "R6 queued advances each applied", nShort, 3);

    // R7: eight retards in eight cycles overflow a queue of three
    clearTally();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      borrowTgl = ~borrowTgl;
    end
    repeat (60) @(negedge clk);
    check(nLong >= 5 && nLong <= 7, "R7 saturating retard queue", nLong, 6);
    check(nShort == 0 && nOdd == 0, "R7 no stray edits", nShort + nOdd, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule